// File: doc/BRIEF.md
# NAND Two-Phase Command Sequencer

This block turns single bus requests into the pin cycles of a NAND flash device. Every piece of control information comes from the request address, and address bit 19 splits requests into two kinds. A command-phase request issues an opcode strobed with CLE, then a chosen number of address bytes strobed with ALE, then an optional closing opcode. A data-phase request moves one 32-bit beat as four byte strobes, written with WE# or read with RE#. It may also end with a closing opcode.

The chip enable stays low across requests, so a page operation can be built from several requests. It goes high when a data-phase request carries the release flag, and it moves when a request names another chip. After any closing opcode the sequencer waits for the device's ready/busy line. A cycle counter bounds that wait and raises an error flag if the line never returns high. Each byte strobe takes two clocks: one clock with the strobe low, then one clock with it high.

Top module: `nand_phase_seq`

## Requirements
- R1: Address bit 19 = 0 makes a command-phase request, which produces only CLE and ALE strobed cycles. Bit 19 = 1 makes a data-phase request, which produces four data strobes with CLE and ALE low.
- R2: In a command phase the opcode in address bits [10:3] goes out first, on one WE# pulse with CLE high, before any address byte.
- R3: Address bits [23:21] give 0 to 7 address bytes, each on one WE# pulse with ALE high. Bytes 1 to 4 come from the write data least-significant byte first. When more than 4 are asked for, the sequencer raises req_ready again for a second beat and takes bytes 5 to 7 from that beat's low bytes.
- R4: When address bit 20 is 1, the opcode in bits [18:11] goes out with CLE high after the address bytes or the data bytes. When bit 20 is 0, no closing opcode is sent.
- R5: A data-phase write issues four WE# pulses carrying write data bytes [7:0], [15:8], [23:16], [31:24] in that order.
- R6: A data-phase read issues four RE# pulses. The byte on nand_io_in at the rising edge of the k-th pulse lands in rsp_rdata[8k+7:8k]. rsp_valid is high for exactly one cycle afterwards.
- R7: A request selects chip enable nand_ce_n[i], where i is address bits [24 +: log2(CHIPS)]. At most one chip enable is ever low.
- R8: A data phase with address bit 21 set releases the chip enable (all high) after its last strobe, including any closing opcode. Without that bit the chip enable stays low.
- R9: A request that names a different chip moves the low chip enable to that chip.
- R10: ecc_last is high for the whole byte transfer of a data phase whose address bit 10 is set, and low at every other time.
- R11: After a closing opcode, req_ready stays low until nand_rb has been high after a guard of WB_CYC cycles.
- R12: If nand_rb stays low for TIMEOUT cycles after a closing opcode, timeout_err goes high and the sequencer returns to idle. The flag clears when the next request is accepted.
- R13: WE# and RE# are never low together. CLE and ALE are never high together. nand_io_oe is low while RE# is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request or second address beat accepted this cycle |
| req_addr | input | 32 | Request address carrying all phase controls |
| req_write | input | 1 | Data phase direction: 1 write, 0 read |
| req_wdata | input | 32 | Write data or address bytes |
| rsp_valid | output | 1 | One-cycle pulse: read data available |
| rsp_rdata | output | 32 | Four bytes read, first byte lowest |
| ecc_last | output | 1 | Marks the final ECC chunk during data transfer |
| timeout_err | output | 1 | Ready/busy wait timed out |
| nand_ce_n | output | CHIPS | Chip enables, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Byte from the flash |
| nand_rb | input | 1 | Ready/busy, low while busy |

## Verification
The assertions assume that nand_rb is synchronous to clk and goes low only in response to a closing opcode. They also assume a requester that holds a request until req_ready and, for more than four address bytes, provides the second beat when asked. The bench changes every input half a clock away from the sampling edge and holds req_valid until acceptance. It drives nand_rb low only around closing opcodes and changes the read byte only while RE# is low. Chip indices stay below CHIPS, so no upper chip-address bits are relied on.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_ADDR, S_WORD2, S_DATA, S_ENDC, S_BUSY
  } seq_state_e;

  // Phase controls unpacked from a request address
  typedef struct packed {
    logic       data_ph;
    logic [2:0] n_addr;
    logic       end_ok;
    logic [7:0] end_cmd;
    logic [7:0] start_cmd;
    logic       clr_ce;
    logic       ecc_last;
  } req_fields_t;

  function automatic req_fields_t decode_addr(input logic [31:0] a);
    req_fields_t f;
    f.data_ph   = a[19];
    f.n_addr    = a[23:21];
    f.end_ok    = a[20];
    f.end_cmd   = a[18:11];
    f.start_cmd = a[10:3];
    f.clr_ce    = a[21];
    f.ecc_last  = a[10];
    return f;
  endfunction

endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int WB_CYC  = 2,
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic rb,
  output logic done,
  output logic expired
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] WB_L = CW'(WB_CYC);
  localparam logic [CW-1:0] TMAX = CW'(TIMEOUT);

  logic [CW-1:0] cnt, cnt_n;
  logic ready_seen, at_limit;

  assign ready_seen = (cnt >= WB_L) && rb;
  assign at_limit   = (cnt == TMAX);
  assign done       = run && (ready_seen || at_limit);
  assign expired    = run && at_limit && !ready_seen;

  always_comb begin
    cnt_n = cnt;
    if (!run)       cnt_n = '0;
    else if (!done) cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/nand_ce_ctrl.sv
module nand_ce_ctrl #(
  parameter int CHIPS = 4,
  localparam int CHIP_W = (CHIPS > 1) ? $clog2(CHIPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_load,
  input  logic [CHIP_W-1:0] sel_idx,
  input  logic              release_ce,
  output logic [CHIPS-1:0]  ce_n
);
  logic              act, act_n;
  logic [CHIP_W-1:0] idx, idx_n;

  always_comb begin
    act_n = act;
    idx_n = idx;
    if (release_ce) begin
      act_n = 1'b0;
    end else if (sel_load) begin
      act_n = 1'b1;
      idx_n = sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      idx <= '0;
    end else begin
      act <= act_n;
      idx <= idx_n;
    end
  end

  for (genvar i = 0; i < CHIPS; i++) begin : g_ce
    assign ce_n[i] = !(act && (idx == CHIP_W'(i)));
  end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int CHIPS   = 4,
  parameter int WB_CYC  = 2,
  parameter int TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             ecc_last,
  output logic             timeout_err,
  output logic [CHIPS-1:0] nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_out,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_in,
  input  logic             nand_rb
);
  localparam int CHIP_W = (CHIPS > 1) ? $clog2(CHIPS) : 1;
  localparam int BEAT_BYTES = 4;
  localparam logic [2:0] LAST_BYTE = 3'(BEAT_BYTES - 1);

  // reset: asserted at once, released on the clock
  logic [1:0] rsync;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i_n = rsync[1];

  seq_state_e  state, state_n;
  req_fields_t fld, fld_n, dec;
  logic        ph, ph_n;
  logic [2:0]  bidx, bidx_n, bidx_inc;
  logic [31:0] sh, sh_n, rbuf, rbuf_n;
  logic        is_wr, is_wr_n, rsp_q, rsp_n, err_q, err_n;
  logic        accept, ce_release, tmr_done, tmr_expired, wr_strobe;
  logic        unused_bits;

  assign dec         = decode_addr(req_addr);
  assign bidx_inc    = bidx + 3'd1;
  assign accept      = (state == S_IDLE) && req_valid;
  assign unused_bits = ^{req_addr[31:24+CHIP_W], req_addr[2:0]};

  always_comb begin
    state_n = state;  fld_n = fld;  ph_n = ph;  bidx_n = bidx;
    sh_n = sh;  rbuf_n = rbuf;  is_wr_n = is_wr;  rsp_n = 1'b0;
    err_n = err_q;  ce_release = 1'b0;
    case (state)
      S_IDLE: if (req_valid) begin
        fld_n = dec;  sh_n = req_wdata;  is_wr_n = req_write;
        bidx_n = '0;  ph_n = 1'b0;  err_n = 1'b0;
        state_n = dec.data_ph ? S_DATA : S_CMD;
      end
      S_CMD: begin
        ph_n = !ph;
        if (ph) state_n = (fld.n_addr != 3'd0) ? S_ADDR :
                          (fld.end_ok ? S_ENDC : S_IDLE);
      end
      S_ADDR: begin
        ph_n = !ph;
        if (ph) begin
          sh_n = sh >> 8;
          bidx_n = bidx_inc;
          if (bidx_inc == fld.n_addr) state_n = fld.end_ok ? S_ENDC : S_IDLE;
          else if (bidx == LAST_BYTE) state_n = S_WORD2;
        end
      end
      S_WORD2: if (req_valid) begin
        sh_n = req_wdata;
        state_n = S_ADDR;
      end
      S_DATA: begin
        ph_n = !ph;
        if (!ph && !is_wr) rbuf_n[{bidx[1:0], 3'b000} +: 8] = nand_io_in;
        if (ph) begin
          sh_n = sh >> 8;
          bidx_n = bidx_inc;
          if (bidx == LAST_BYTE) begin
            rsp_n = !is_wr;
            if (fld.end_ok) state_n = S_ENDC;
            else begin
              state_n = S_IDLE;
              ce_release = fld.clr_ce;
            end
          end
        end
      end
      S_ENDC: begin
        ph_n = !ph;
        if (ph) begin
          state_n = S_BUSY;
          ce_release = fld.data_ph && fld.clr_ce;
        end
      end
      S_BUSY: if (tmr_done) begin
        state_n = S_IDLE;
        err_n = err_q | tmr_expired;
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state <= S_IDLE;  fld <= '0;  ph <= 1'b0;  bidx <= '0;
      sh <= '0;  rbuf <= '0;  is_wr <= 1'b0;  rsp_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      state <= state_n;  fld <= fld_n;  ph <= ph_n;  bidx <= bidx_n;
      sh <= sh_n;  rbuf <= rbuf_n;  is_wr <= is_wr_n;  rsp_q <= rsp_n;  err_q <= err_n;
    end
  end

  nand_busy_timer #(.WB_CYC(WB_CYC), .TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst_n(rst_i_n), .run(state == S_BUSY), .rb(nand_rb),
    .done(tmr_done), .expired(tmr_expired)
  );

  nand_ce_ctrl #(.CHIPS(CHIPS)) u_ce (
    .clk(clk), .rst_n(rst_i_n), .sel_load(accept),
    .sel_idx(req_addr[24 +: CHIP_W]), .release_ce(ce_release), .ce_n(nand_ce_n)
  );

  assign wr_strobe   = (state == S_CMD) || (state == S_ADDR) || (state == S_ENDC) ||
                       ((state == S_DATA) && is_wr);
  assign req_ready   = (state == S_IDLE) || (state == S_WORD2);
  assign nand_cle    = (state == S_CMD) || (state == S_ENDC);
  assign nand_ale    = (state == S_ADDR);
  assign nand_we_n   = !(wr_strobe && !ph);
  assign nand_re_n   = !((state == S_DATA) && !is_wr && !ph);
  assign nand_io_oe  = wr_strobe;
  assign nand_io_out = (state == S_CMD)  ? fld.start_cmd :
                       (state == S_ENDC) ? fld.end_cmd : sh[7:0];
  assign ecc_last    = (state == S_DATA) && fld.ecc_last;
  assign rsp_valid   = rsp_q;
  assign rsp_rdata   = rbuf;
  assign timeout_err = err_q;
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk
  import nand_seq_pkg::*;
#(
  parameter int CHIPS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input seq_state_e       st,
  input logic [CHIPS-1:0] ce_n,
  input logic             we_n,
  input logic             re_n,
  input logic             cle,
  input logic             ale,
  input logic             io_oe,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rb,
  input logic             timeout_err,
  input logic             ecc_last
);
  a_r7_ce_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
  a_r13_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r13_cle_ale_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  a_r13_read_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);
  a_r2_cmd_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (cle && !we_n) |-> io_oe);
  a_r6_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  a_r10_ecc_with_chip: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_last |-> (ce_n != {CHIPS{1'b1}}));
  a_r11_ready_needs_rb: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_ready) && $past(st) == S_BUSY) |-> ($past(rb) || timeout_err));
  a_r12_err_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> ($past(st) == S_BUSY && !$past(rb)));
endmodule

bind nand_phase_seq nand_seq_chk #(.CHIPS(CHIPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .ce_n(nand_ce_n), .we_n(nand_we_n),
  .re_n(nand_re_n), .cle(nand_cle), .ale(nand_ale), .io_oe(nand_io_oe),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rb(nand_rb),
  .timeout_err(timeout_err), .ecc_last(ecc_last)
);

// File: tb/nand_phase_seq_test.sv
module nand_phase_seq_test;
  logic        clk, rst_n, req_valid, req_write, nand_rb;
  logic [31:0] req_addr, req_wdata;
  logic [7:0]  nand_io_in;
  logic        req_ready, rsp_valid, ecc_last, timeout_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;

  int checks = 0, failures = 0;
  int ev_n = 0, rsp_cnt = 0, ecc_cnt = 0, rd_k = 0, viol = 0;
  logic [1:0]  ev_k [0:31];
  logic [7:0]  ev_b [0:31];
  logic [7:0]  rd_pat [0:3];
  logic [31:0] got_rdata;

  nand_phase_seq #(.CHIPS(4), .WB_CYC(2), .TIMEOUT(60)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ecc_last(ecc_last),
    .timeout_err(timeout_err), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb(nand_rb)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // bus monitor and flash read model, away from the active edge
  always @(negedge clk) begin
    if (!nand_we_n && ev_n < 32) begin
      ev_k[ev_n] = nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd0);
      ev_b[ev_n] = nand_io_out;
      ev_n++;
    end
    if (!nand_re_n) begin
      if (ecc_last) ecc_cnt++;
      nand_io_in = rd_pat[rd_k % 4];
      rd_k++;
    end
    if (rsp_valid) begin got_rdata = rsp_rdata; rsp_cnt++; end
    if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale) || (!nand_re_n && nand_io_oe))
      viol++;
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_ev(input int i, input logic [1:0] k, input logic [7:0] b, input string tag);
    chk(ev_k[i] == k && ev_b[i] == b, tag, {22'd0, ev_k[i], ev_b[i]}, {22'd0, k, b});
  endtask

  function automatic logic [31:0] cmd_a(input int chip, input int na, input logic eo,
                                        input logic [7:0] ec, input logic [7:0] sc);
    return (32'(chip) << 24) | (32'(na) << 21) | (32'(eo) << 20) | (32'(ec) << 11) | (32'(sc) << 3);
  endfunction

  function automatic logic [31:0] dat_a(input int chip, input logic clr, input logic eo,
                                        input logic [7:0] ec, input logic ecc);
    return (32'(chip) << 24) | (32'(clr) << 21) | (32'(eo) << 20) | (32'h1 << 19) |
           (32'(ec) << 11) | (32'(ecc) << 10);
  endfunction

  task automatic clr_mon();
    ev_n = 0; rsp_cnt = 0; ecc_cnt = 0; rd_k = 0;
  endtask

  task automatic send(input logic [31:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = w;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(nand_ce_n == 4'hF, "R7 reset ce", {28'd0, nand_ce_n}, 32'hF);
    chk(nand_we_n && nand_re_n && !nand_cle && !nand_ale, "R13 reset strobes",
        {28'd0, nand_we_n, nand_re_n, nand_cle, nand_ale}, 32'hC);
    chk(req_ready && !timeout_err && !rsp_valid, "R11 reset ready",
        {29'd0, req_ready, timeout_err, rsp_valid}, 32'h4);
  endtask

  task automatic t_cmd3_busy();
    int n;
    clr_mon();
    nand_rb = 1'b0;
    send(cmd_a(0, 3, 1'b1, 8'h30, 8'h00), 32'h00CCBBAA, 1'b1);
    n = 0;
    while (ev_n < 5 && n < 100) begin @(negedge clk); n++; end
    repeat (10) @(negedge clk);
    chk(!req_ready, "R11 held while busy", {31'd0, req_ready}, 32'd0);
    nand_rb = 1'b1;
    n = 0;
    while (!req_ready && n < 20) begin @(negedge clk); n++; end
    chk(req_ready && n <= 4, "R11 release after rb", n, 32'd3);
    chk(ev_n == 5, "R3 event count", ev_n, 5);
    chk_ev(0, 2'd1, 8'h00, "R2 start command first");
    chk_ev(1, 2'd2, 8'hAA, "R3 addr byte0");
    chk_ev(2, 2'd2, 8'hBB, "R3 addr byte1");
    chk_ev(3, 2'd2, 8'hCC, "R3 addr byte2");
    chk_ev(4, 2'd1, 8'h30, "R4 end command");
    chk(nand_ce_n == 4'hE, "R7 chip0 selected", {28'd0, nand_ce_n}, 32'hE);
  endtask

  task automatic t_cmd5();
    clr_mon();
    send(cmd_a(0, 5, 1'b0, 8'h00, 8'h80), 32'h44332211, 1'b1);
    send(32'h0, 32'hEEEEEE55, 1'b1);
    wait_idle();
    chk(ev_n == 6, "R4 no end command", ev_n, 6);
    chk_ev(0, 2'd1, 8'h80, "R2 start command");
    chk_ev(4, 2'd2, 8'h44, "R3 addr byte3");
    chk_ev(5, 2'd2, 8'h55, "R3 addr byte4 from second beat");
  endtask

  task automatic t_write();
    clr_mon();
    send(dat_a(0, 1'b0, 1'b0, 8'h00, 1'b0), 32'hDDCCBBAA, 1'b1);
    wait_idle();
    chk(ev_n == 4, "R1 data write count", ev_n, 4);
    chk_ev(0, 2'd0, 8'hAA, "R5 write byte0");
    chk_ev(1, 2'd0, 8'hBB, "R5 write byte1");
    chk_ev(2, 2'd0, 8'hCC, "R5 write byte2");
    chk_ev(3, 2'd0, 8'hDD, "R5 write byte3");
    chk(ecc_cnt == 0 && rsp_cnt == 0, "R10 no ecc flag", ecc_cnt, 0);
    chk(nand_ce_n == 4'hE, "R8 ce kept", {28'd0, nand_ce_n}, 32'hE);
  endtask

  task automatic t_read();
    clr_mon();
    rd_pat[0] = 8'h5A; rd_pat[1] = 8'hA5; rd_pat[2] = 8'h3C; rd_pat[3] = 8'hC3;
    send(dat_a(0, 1'b1, 1'b0, 8'h00, 1'b1), 32'h0, 1'b0);
    wait_idle();
    @(negedge clk);
    chk(rsp_cnt == 1, "R6 one response pulse", rsp_cnt, 1);
    chk(got_rdata == 32'hC33CA55A, "R6 read data", got_rdata, 32'hC33CA55A);
    chk(ev_n == 0 && rd_k == 4, "R6 four read strobes", rd_k, 4);
    chk(ecc_cnt == 4, "R10 ecc flag on data", ecc_cnt, 4);
    chk(!ecc_last, "R10 ecc flag low idle", {31'd0, ecc_last}, 0);
    chk(nand_ce_n == 4'hF, "R8 ce released", {28'd0, nand_ce_n}, 32'hF);
  endtask

  task automatic t_chip_switch();
    clr_mon();
    send(cmd_a(2, 0, 1'b0, 8'h00, 8'hFF), 32'h0, 1'b1);
    wait_idle();
    chk(nand_ce_n == 4'hB, "R7 chip2 selected", {28'd0, nand_ce_n}, 32'hB);
    send(cmd_a(1, 0, 1'b0, 8'h00, 8'h90), 32'h0, 1'b1);
    wait_idle();
    chk(nand_ce_n == 4'hD, "R9 moved to chip1", {28'd0, nand_ce_n}, 32'hD);
    chk(ev_n == 2 && ev_b[1] == 8'h90, "R2 lone opcodes", ev_n, 2);
  endtask

  task automatic t_write_end_clear();
    clr_mon();
    send(dat_a(1, 1'b1, 1'b1, 8'h10, 1'b0), 32'h04030201, 1'b1);
    wait_idle();
    chk(ev_n == 5, "R4 data end count", ev_n, 5);
    chk_ev(3, 2'd0, 8'h04, "R5 last data byte");
    chk_ev(4, 2'd1, 8'h10, "R4 end after data");
    chk(nand_ce_n == 4'hF, "R8 released after end", {28'd0, nand_ce_n}, 32'hF);
  endtask

  task automatic t_timeout();
    int n;
    clr_mon();
    nand_rb = 1'b0;
    send(cmd_a(3, 0, 1'b1, 8'hD0, 8'h60), 32'h0, 1'b1);
    n = 0;
    while (!timeout_err && n < 200) begin @(negedge clk); n++; end
    chk(timeout_err, "R12 timeout raised", {31'd0, timeout_err}, 1);
    chk(req_ready, "R12 back to idle", {31'd0, req_ready}, 1);
    nand_rb = 1'b1;
    send(cmd_a(3, 0, 1'b0, 8'h00, 8'hFF), 32'h0, 1'b1);
    wait_idle();
    chk(!timeout_err, "R12 cleared on accept", {31'd0, timeout_err}, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_wdata = '0; req_write = 1'b0;
    nand_rb = 1'b1; nand_io_in = '0;
    for (int i = 0; i < 4; i++) rd_pat[i] = 8'h00;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_cmd3_busy();
    t_cmd5();
    t_write();
    t_read();
    t_chip_switch();
    t_write_end_clear();
    t_timeout();
    chk(viol == 0, "R13 strobe exclusion", viol, 0);
    chk(ev_n >= 1, "R1 command events seen", ev_n, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule